// File: doc/BRIEF.md
# Stacked-Carrier Multilevel PWM Modulator

This block drives the switches of one leg of an N-level diode-clamped inverter. It compares a reference against N-1 digital triangle carriers. The carriers are stacked on top of each other so that together they cover the full output range. Every carrier is built from one shared up/down ramp. Depending on the selected disposition, a carrier uses that ramp directly or its mirror image. The three dispositions are: all carriers in phase; carriers above the midpoint opposed to those below it; or each carrier opposed to its neighbour.

The reference comes from one of two places. The first is an internal twelve-step sine table, which advances once every programmable number of carrier periods. The second is an external signed sample. In either case the reference can be used live, or held at the value latched at the start of each carrier period (regular sampling). The block counts how many carriers the scaled reference exceeds and registers that count as the output level. From the level it also registers a window of 2(N-1) clamped-switch gate bits.

Top module: `stacked_carrier_pwm`

## Requirements
- R1: A shared CW-bit ramp starts at 0 rising after reset. It moves by exactly one count on each cycle with `step_en` high, turns around at 2^CW-1 and at 0, and holds when `step_en` is low. Carrier k (k=0 lowest, NC=N_LEVELS-1 carriers) has the value k*2^CW + shape, where shape is either the ramp or (2^CW-1 - ramp).
- R2: One cycle after a clock edge, `level` equals the number of carriers for which ref*NC > carrier, using the ramp, mode and reference in effect before that edge. Here ref is the 8-bit offset-binary reference.
- R3: `disp_mode` 0 (in phase): every carrier uses the ramp itself.
- R4: `disp_mode` 1 (opposed about the midpoint): carriers with k < NC/2 (integer division) use the mirrored ramp; the others use the ramp.
- R5: `disp_mode` 2 (alternating): carrier k uses the mirrored ramp when (NC-1-k) is odd. For N_LEVELS=3 this yields the same carriers, and so the same outputs, as mode 1.
- R6: Mode 3 behaves as mode 0. A new `disp_mode` value is taken only on a valley, that is an enabled step that takes the ramp from 1 to 0. After reset the active mode is 0.
- R7: The internal table holds 128,192,238,255,238,192,128,64,17,0,17,64 at index 0..11. The index starts at 0 and advances, wrapping 11 to 0, on every max(`ratio`,1)-th valley.
- R8: With `ref_src`=1 the reference is the signed `ext_ref` converted to offset binary by inverting its MSB. With `ref_src`=0 it is the table entry at the current index.
- R9: With `hold`=1 the reference is the value latched at the most recent valley: the table entry in effect just after that valley's advance, or the converted `ext_ref` of that cycle. This latch is 128 after reset.
- R10: `gates` has 2*NC bits. Bit b is high exactly when level <= b <= level+NC-1. For N_LEVELS=3 this gives 1100 at level 2, 0110 at level 1 and 0011 at level 0 (bit 3 = upper outer switch).
- R11: While `rst_n` is low, `level` is 0 and `gates` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance the carrier ramp this cycle |
| disp_mode | input | 2 | Carrier disposition: 0 in phase, 1 opposed about midpoint, 2 alternating, 3 as 0 |
| ratio | input | RW | Carrier periods per table step (0 treated as 1) |
| ref_src | input | 1 | 1 selects `ext_ref`, 0 the internal table |
| ext_ref | input | 8 | Signed external reference sample |
| hold | input | 1 | 1 uses the reference latched at the last valley |
| level | output | $clog2(N_LEVELS) | Registered output level index |
| gates | output | 2*(N_LEVELS-1) | Registered clamped-switch gate bits, MSB topmost |

## Verification
At one valley three things coincide: a pending mode change is accepted, the table index may advance, and the held reference is relatched. The slicer output of that same edge must still reflect the old mode, the old ramp and the old reference. The bench changes the mode at arbitrary points inside a period, and runs held and live references with ratios of 0, 1 and 3 so that table steps and latches fall on the same valleys as mode switches. A cycle-accurate model predicts every output of a five-level and a three-level instance, and each prediction is compared on the following falling edge.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        DISP_INPHASE = 2'd0,
        DISP_SPLIT   = 2'd1,
        DISP_ALT     = 2'd2,
        DISP_SPARE   = 2'd3
    } disp_e;

    localparam int TABLE_LEN = 12;

    // Offset-binary sine codes at 30-degree steps.
    function automatic logic [7:0] sine_code(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'd128;
            4'd1:    return 8'd192;
            4'd2:    return 8'd238;
            4'd3:    return 8'd255;
            4'd4:    return 8'd238;
            4'd5:    return 8'd192;
            4'd6:    return 8'd128;
            4'd7:    return 8'd64;
            4'd8:    return 8'd17;
            4'd9:    return 8'd0;
            4'd10:   return 8'd17;
            4'd11:   return 8'd64;
            default: return 8'd128;
        endcase
    endfunction

    // Whether carrier k of nc uses the mirrored ramp.
    function automatic logic carrier_mirrored(input disp_e m, input int k, input int nc);
        case (m)
            DISP_SPLIT: return (k < nc / 2);
            DISP_ALT:   return (((nc - 1 - k) % 2) == 1);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spc_carrier.sv
module spc_carrier
    import spc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic [1:0]    mode_i,
    output logic [CW-1:0] ramp_o,
    output disp_e         mode_o,
    output logic          valley_o
);
    localparam logic [CW-1:0] TURN_HI = CW'((1 << CW) - 2);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        logic [CW-1:0] ramp;
        logic          up;
        disp_e         mode;
    } car_st_t;

    car_st_t st_d, st_q;
    logic    valley_d;

    always_comb begin
        st_d     = st_q;
        valley_d = 1'b0;
        if (step_en) begin
            if (st_q.up) begin
                st_d.ramp = st_q.ramp + ONE;
                if (st_q.ramp == TURN_HI) st_d.up = 1'b0;
            end else begin
                st_d.ramp = st_q.ramp - ONE;
                if (st_q.ramp == ONE) begin
                    st_d.up   = 1'b1;
                    valley_d  = 1'b1;
                    st_d.mode = disp_e'(mode_i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ramp <= '0;
            st_q.up   <= 1'b1;
            st_q.mode <= DISP_INPHASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ramp_o   = st_q.ramp;
    assign mode_o   = st_q.mode;
    assign valley_o = valley_d;

    p_ramp_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(st_q.ramp));
    p_ramp_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (st_q.ramp != $past(st_q.ramp)));
    p_mode_only_at_valley_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_o |=> $stable(st_q.mode));

endmodule

// File: rtl/spc_refgen.sv
module spc_refgen
    import spc_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valley_i,
    input  logic [RW-1:0] ratio_i,
    input  logic          ref_src_i,
    input  logic [7:0]    ext_ref_i,
    input  logic          hold_i,
    output logic [7:0]    ref_o
);
    localparam logic [3:0] LAST_IDX = 4'(TABLE_LEN - 1);

    typedef struct packed {
        logic [3:0]    idx;
        logic [RW-1:0] per;
        logic [7:0]    samp;
    } ref_st_t;

    ref_st_t       st_d, st_q;
    logic [RW-1:0] per_lim;
    logic [7:0]    ext_ob;

    assign ext_ob  = {~ext_ref_i[7], ext_ref_i[6:0]};
    assign per_lim = (ratio_i == '0) ? '0 : ratio_i - RW'(1);

    always_comb begin
        st_d = st_q;
        if (valley_i) begin
            if (st_q.per >= per_lim) begin
                st_d.per = '0;
                st_d.idx = (st_q.idx == LAST_IDX) ? 4'd0 : st_q.idx + 4'd1;
            end else begin
                st_d.per = st_q.per + RW'(1);
            end
            st_d.samp = ref_src_i ? ext_ob : sine_code(st_d.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx  <= '0;
            st_q.per  <= '0;
            st_q.samp <= 8'd128;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o = hold_i ? st_q.samp : (ref_src_i ? ext_ob : sine_code(st_q.idx));

    p_idx_in_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= LAST_IDX);
    p_idx_at_valley_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_i |=> $stable(st_q.idx));
    p_latch_at_valley_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_i |=> $stable(st_q.samp));

endmodule

// File: rtl/spc_slicer.sv
module spc_slicer
    import spc_pkg::*;
#(
    parameter int N_LEVELS = 5,
    parameter int CW       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CW-1:0]               ramp_i,
    input  disp_e                       mode_i,
    input  logic [7:0]                  ref_i,
    output logic [$clog2(N_LEVELS)-1:0] level_o,
    output logic [2*(N_LEVELS-1)-1:0]   gates_o
);
    localparam int NC   = N_LEVELS - 1;
    localparam int SPAN = 1 << CW;
    localparam int LW   = $clog2(NC * SPAN) + 1;
    localparam int LVW  = $clog2(N_LEVELS);
    localparam int GW   = 2 * NC;

    typedef struct packed {
        logic [LVW-1:0] level;
        logic [GW-1:0]  gates;
    } out_t;

    out_t          out_d, out_q;
    logic [LW-1:0] ref_lvl;
    logic [NC-1:0] above;

    assign ref_lvl = LW'(ref_i) * LW'(NC);

    for (genvar k = 0; k < NC; k++) begin : g_carrier
        logic          mirror;
        logic [CW-1:0] shape;
        logic [LW-1:0] car;
        assign mirror   = carrier_mirrored(mode_i, k, NC);
        assign shape    = mirror ? ~ramp_i : ramp_i;
        assign car      = LW'(k * SPAN) + LW'(shape);
        assign above[k] = (ref_lvl > car);
    end

    always_comb begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < NC; k++) cnt += int'(above[k]);
        out_d.level = LVW'(cnt);
        for (int b = 0; b < GW; b++) out_d.gates[b] = (b >= cnt) && (b <= cnt + NC - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign level_o = out_q.level;
    assign gates_o = out_q.gates;

    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (int'(out_q.level) <= NC));
    p_gate_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(out_q.gates) == NC));
    p_gate_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_q.gates[out_q.level]);

endmodule

// File: rtl/stacked_carrier_pwm.sv
module stacked_carrier_pwm
    import spc_pkg::*;
#(
    parameter int N_LEVELS = 5,
    parameter int CW       = 8,
    parameter int RW       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_en,
    input  logic [1:0]                  disp_mode,
    input  logic [RW-1:0]               ratio,
    input  logic                        ref_src,
    input  logic signed [7:0]           ext_ref,
    input  logic                        hold,
    output logic [$clog2(N_LEVELS)-1:0] level,
    output logic [2*(N_LEVELS-1)-1:0]   gates
);
    logic [CW-1:0] ramp;
    disp_e         mode_act;
    logic          valley;
    logic [7:0]    ref_byte;

    spc_carrier #(.CW(CW)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .mode_i  (disp_mode),
        .ramp_o  (ramp),
        .mode_o  (mode_act),
        .valley_o(valley)
    );

    spc_refgen #(.RW(RW)) u_refgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .valley_i (valley),
        .ratio_i  (ratio),
        .ref_src_i(ref_src),
        .ext_ref_i(ext_ref),
        .hold_i   (hold),
        .ref_o    (ref_byte)
    );

    spc_slicer #(.N_LEVELS(N_LEVELS), .CW(CW)) u_slicer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ramp_i (ramp),
        .mode_i (mode_act),
        .ref_i  (ref_byte),
        .level_o(level),
        .gates_o(gates)
    );

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> ((level == '0) && (gates == '0)));

endmodule

// File: tb/sim_stacked_carrier_pwm.sv
module sim_stacked_carrier_pwm;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_en = 1'b0;
    logic [1:0]        disp_mode = 2'd0;
    logic [7:0]        ratio = 8'd1;
    logic              ref_src = 1'b0;
    logic signed [7:0] ext_ref = '0;
    logic              hold = 1'b0;
    logic [2:0]        lv5;
    logic [7:0]        g5;
    logic [1:0]        lv3;
    logic [3:0]        g3;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    stacked_carrier_pwm #(.N_LEVELS(5)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .disp_mode(disp_mode),
        .ratio(ratio), .ref_src(ref_src), .ext_ref(ext_ref), .hold(hold),
        .level(lv5), .gates(g5));

    stacked_carrier_pwm #(.N_LEVELS(3)) u1 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .disp_mode(disp_mode),
        .ratio(ratio), .ref_src(ref_src), .ext_ref(ext_ref), .hold(hold),
        .level(lv3), .gates(g3));

    typedef struct { int lv5; int g5; int lv3; int g3; } exp_t;
    exp_t q[$];

    int sine_tab[12] = '{128, 192, 238, 255, 238, 192, 128, 64, 17, 0, 17, 64};
    int m_ramp, m_up, m_mode, m_idx, m_per, m_samp;

    function automatic int exp_level(int r, int t, int mode, int nc);
        int cnt = 0;
        for (int k = 0; k < nc; k++) begin
            bit flip;
            int shape;
            flip  = (mode == 1) ? (k < nc / 2) : (mode == 2) ? (((nc - 1 - k) & 1) == 1) : 1'b0;
            shape = flip ? 255 - t : t;
            if (r * nc > k * 256 + shape) cnt++;
        end
        return cnt;
    endfunction

    function automatic int exp_gates(int l, int nc);
        int g = 0;
        for (int b = 0; b < 2 * nc; b++) if (b >= l && b <= l + nc - 1) g |= (1 << b);
        return g;
    endfunction

    function automatic int live_ref(int idx);
        return ref_src ? ((int'(ext_ref) + 128) & 255) : sine_tab[idx];
    endfunction

    // Predictor: runs the requirement model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ramp = 0; m_up = 1; m_mode = 0; m_idx = 0; m_per = 0; m_samp = 128;
        end else begin
            exp_t it;
            int   r, lim;
            bit   valley;
            r      = hold ? m_samp : live_ref(m_idx);
            it.lv5 = exp_level(r, m_ramp, m_mode, 4);
            it.g5  = exp_gates(it.lv5, 4);
            it.lv3 = exp_level(r, m_ramp, m_mode, 2);
            it.g3  = exp_gates(it.lv3, 2);
            q.push_back(it);
            valley = step_en && !m_up && (m_ramp == 1);
            if (step_en) begin
                if (m_up) begin m_ramp++; if (m_ramp == 255) m_up = 0; end
                else      begin m_ramp--; if (m_ramp == 0)   m_up = 1; end
            end
            if (valley) begin
                m_mode = (disp_mode == 3) ? 0 : int'(disp_mode);
                lim = (ratio == 0) ? 0 : int'(ratio) - 1;
                if (m_per >= lim) begin m_per = 0; m_idx = (m_idx == 11) ? 0 : m_idx + 1; end
                else m_per++;
                m_samp = live_ref(m_idx);
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Monitor: compares outputs on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R11 reset level u0", int'(lv5), 0);
            check("R11 reset gates u0", int'(g5), 0);
            check("R11 reset gates u1", int'(g3), 0);
        end else if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R2 level N=5", int'(lv5), e.lv5);
            check("R10 gates N=5", int'(g5), e.g5);
            check("R2 level N=3", int'(lv3), e.lv3);
            check("R10 gates N=3", int'(g3), e.g3);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        tick(4);
        rst_n = 1'b1; step_en = 1'b1;
        tag = "R3"; tick(6200);
        tag = "R4"; disp_mode = 2'd1; tick(3000);
        tag = "R6"; disp_mode = 2'd2; tick(600);
        tag = "R5"; tick(2500);
        tag = "R6"; disp_mode = 2'd3; tick(1100);
        disp_mode = 2'd0;
        tag = "R7"; ratio = 8'd3; tick(4000);
        ratio = 8'd0; tick(1100);
        ratio = 8'd1;
        tag = "R9"; hold = 1'b1; disp_mode = 2'd1; tick(3000);
        hold = 1'b0;
        tag = "R8"; ref_src = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (i % 37 == 0) ext_ref = ext_ref + 8'sd13;
            tick(1);
        end
        tag = "R9"; hold = 1'b1; disp_mode = 2'd2;
        for (int i = 0; i < 2000; i++) begin
            if (i % 23 == 0) ext_ref = ext_ref - 8'sd29;
            tick(1);
        end
        tag = "R1"; hold = 1'b0; ref_src = 1'b0; disp_mode = 2'd0;
        for (int i = 0; i < 2000; i++) begin
            step_en = (i % 3) != 0;
            tick(1);
        end
        step_en = 1'b0; tick(20);
        tick(2);
        finish_run();
    end

endmodule